// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns a virtual address into a physical address by comparing the page-number part of the address with every stored entry at once. Each entry maps one virtual page to one physical frame. It also carries a valid flag, a write-protect flag, a referenced flag and a modified flag. Entries may be loaded into any slot, in any order. The page offset passes through unchanged. The physical address is the matched frame number joined to that offset.

A lookup is presented for one cycle. It is answered on the next cycle with a response-valid pulse, the physical address and a two-bit exception code. A miss is reported as a page fault, so the caller can refill the buffer in software. Software loads an entry through a write port at a chosen slot. A flush input empties the whole buffer in one cycle, for use on a context switch. A probe port shows the valid, referenced and modified flags of one slot.

The defaults are 32-bit addresses, 128-byte pages and 4 entries. With these values the offset is 7 bits wide and the page and frame numbers are each 25 bits wide.

Top module: `page_xlate_buffer`

## Requirements
- R1: After reset every entry is invalid, so the probe reads valid=0 for every slot, and rspValid is low.
- R2: For a lookup with reqValid high, rspValid is high exactly one cycle later and low otherwise. On a hit, rspExc is 0 and rspPhysAddr is the stored frame number in bits 31:7 followed by the unchanged address bits 6:0.
- R3: If no valid entry holds the lookup page number (address bits 31:7), rspExc is 1 (page fault) and rspPhysAddr is 0.
- R4: A write lookup (reqWrite=1) that hits an entry whose write-protect flag is set returns rspExc 2 and rspPhysAddr 0. The referenced and modified flags of that entry do not change.
- R5: reqSize encodes 0 for a byte, 1 for a halfword, and 2 or 3 for a word. A halfword with address bit 0 set, or a word with address bits 1:0 not zero, returns rspExc 3 even if the page would miss. That lookup changes no flag. Byte accesses are never misaligned.
- R6: A read lookup that succeeds sets the referenced flag of the matched entry and leaves its modified flag unchanged.
- R7: A write lookup that succeeds sets both the referenced and the modified flag of the matched entry.
- R8: A flush makes every entry invalid on the next cycle. Later lookups of pages that were present return a page fault.
- R9: A software entry write in the same cycle as a flush still stores its fields, but the written entry stays invalid.
- R10: When more than one valid entry holds the lookup page number, the entry with the lowest slot index supplies the frame number.
- R11: A software entry write loads the page number, frame number, valid flag and write-protect flag, and clears the referenced and modified flags. An entry loaded with valid=0 never matches.
- R12: A read lookup that hits a write-protected entry succeeds with rspExc 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Lookup request strobe |
| reqAddr | input | 32 | Virtual address of the lookup |
| reqWrite | input | 1 | 1 for a write access, 0 for a read |
| reqSize | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| flush | input | 1 | Invalidate every entry |
| wrEn | input | 1 | Software entry write strobe |
| wrIdx | input | 2 | Slot to be written |
| wrVpn | input | 25 | Virtual page number to store |
| wrPfn | input | 25 | Physical frame number to store |
| wrValid | input | 1 | Valid flag to store |
| wrReadOnly | input | 1 | Write-protect flag to store |
| probeIdx | input | 2 | Slot shown on the probe outputs |
| probeValid | output | 1 | Valid flag of the probed slot |
| probeUse | output | 1 | Referenced flag of the probed slot |
| probeDirty | output | 1 | Modified flag of the probed slot |
| rspValid | output | 1 | Response strobe, one cycle after a request |
| rspPhysAddr | output | 32 | Translated address, 0 on any exception |
| rspExc | output | 2 | 0 none, 1 page fault, 2 write-protect, 3 misaligned |

## Verification
The assertions assume that a lookup, a software write and a flush each last one cycle. They also assume that the probe index is held steady around a flush, so the slot seen after the flush is one the flush cleared. The flush check further assumes that no software write lands in the cycle right after a flush. The bench drives every operation alone between two falling clock edges and never overlaps a lookup with a write or a flush. The one exception is the directed case that pairs a flush with a software write. Random page numbers are drawn from a small pool so that hits, misses and duplicate entries all occur often.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    EXC_NONE      = 2'd0,
    EXC_PAGEFAULT = 2'd1,
    EXC_READONLY  = 2'd2,
    EXC_MISALIGN  = 2'd3
  } xlat_exc_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic flush;   // clear all valid flags
    logic load;    // software entry write
    logic touch;   // set referenced flag of the selected entry
    logic mark;    // also set modified flag
  } xlat_strobe_t;

endpackage

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 25,
  parameter int PFN_W   = 25,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  xlat_strobe_t       ctl,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [VPN_W-1:0]   wrVpn,
  input  logic [PFN_W-1:0]   wrPfn,
  input  logic               wrValid,
  input  logic               wrReadOnly,
  input  logic [VPN_W-1:0]   lookVpn,
  input  logic [IDX_W-1:0]   selIdx,
  output logic [ENTRIES-1:0] matchVec,
  output logic [PFN_W-1:0]   selPfn,
  output logic               selRo,
  input  logic [IDX_W-1:0]   probeIdx,
  output logic               probeValid,
  output logic               probeUse,
  output logic               probeDirty
);

  logic [VPN_W-1:0]   vpnQ [ENTRIES];
  logic [PFN_W-1:0]   pfnQ [ENTRIES];
  logic [ENTRIES-1:0] validQ, roQ, useQ, dirtyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      roQ    <= '0;
      useQ   <= '0;
      dirtyQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpnQ[i] <= '0;
        pfnQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ctl.load && wrIdx == IDX_W'(i)) begin
          vpnQ[i]   <= wrVpn;
          pfnQ[i]   <= wrPfn;
          roQ[i]    <= wrReadOnly;
          validQ[i] <= wrValid && !ctl.flush;
          useQ[i]   <= 1'b0;
          dirtyQ[i] <= 1'b0;
        end else if (ctl.flush) begin
          validQ[i] <= 1'b0;
        end else if (ctl.touch && selIdx == IDX_W'(i)) begin
          useQ[i] <= 1'b1;
          if (ctl.mark) dirtyQ[i] <= 1'b1;
        end
      end
    end
  end

  // Parallel compare, one comparator per entry
  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
    assign matchVec[gi] = validQ[gi] && (vpnQ[gi] == lookVpn);
  end

  assign selPfn     = pfnQ[selIdx];
  assign selRo      = roQ[selIdx];
  assign probeValid = validQ[probeIdx];
  assign probeUse   = useQ[probeIdx];
  assign probeDirty = dirtyQ[probeIdx];

endmodule

// File: rtl/xlat_control.sv
module xlat_control
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 32,
  parameter int OFFS_W  = 7,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PFN_W  = ADDR_W - OFFS_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqWrite,
  input  logic [1:0]         reqSize,
  input  logic               flush,
  input  logic               wrEn,
  input  logic [ENTRIES-1:0] matchVec,
  input  logic [PFN_W-1:0]   selPfn,
  input  logic               selRo,
  output logic [IDX_W-1:0]   selIdx,
  output xlat_strobe_t       ctl,
  output logic               rspValid,
  output logic [ADDR_W-1:0]  rspPhysAddr,
  output logic [1:0]         rspExc
);

  xlat_exc_e excNext;
  logic      misaligned;

  // Lowest index wins on duplicate matches
  always_comb begin
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (matchVec[i]) selIdx = IDX_W'(i);
  end

  assign misaligned = (reqSize == 2'd1 && reqAddr[0]) ||
                      (reqSize[1] && reqAddr[1:0] != 2'b00);

  always_comb begin
    if (misaligned)             excNext = EXC_MISALIGN;
    else if (matchVec == '0)    excNext = EXC_PAGEFAULT;
    else if (reqWrite && selRo) excNext = EXC_READONLY;
    else                        excNext = EXC_NONE;
  end

  always_comb begin
    ctl.flush = flush;
    ctl.load  = wrEn;
    ctl.touch = reqValid && (excNext == EXC_NONE);
    ctl.mark  = reqWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspExc      <= 2'd0;
      rspPhysAddr <= '0;
    end else begin
      rspValid    <= reqValid;
      rspExc      <= reqValid ? excNext : 2'd0;
      rspPhysAddr <= (reqValid && excNext == EXC_NONE)
                     ? {selPfn, reqAddr[OFFS_W-1:0]} : '0;
    end
  end

endmodule

// File: rtl/page_xlate_buffer.sv
module page_xlate_buffer
  import xlat_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 128,
  parameter int ENTRIES    = 4,
  localparam int OFFS_W    = $clog2(PAGE_BYTES),
  localparam int VPN_W     = ADDR_W - OFFS_W,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic              flush,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [VPN_W-1:0]  wrPfn,
  input  logic              wrValid,
  input  logic              wrReadOnly,
  input  logic [IDX_W-1:0]  probeIdx,
  output logic              probeValid,
  output logic              probeUse,
  output logic              probeDirty,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspPhysAddr,
  output logic [1:0]        rspExc
);

  xlat_strobe_t       ctl;
  logic [ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]   selIdx;
  logic [VPN_W-1:0]   selPfn;
  logic               selRo;

  xlat_datapath #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(VPN_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .wrIdx(wrIdx), .wrVpn(wrVpn), .wrPfn(wrPfn),
    .wrValid(wrValid), .wrReadOnly(wrReadOnly),
    .lookVpn(reqAddr[ADDR_W-1:OFFS_W]), .selIdx(selIdx),
    .matchVec(matchVec), .selPfn(selPfn), .selRo(selRo),
    .probeIdx(probeIdx), .probeValid(probeValid),
    .probeUse(probeUse), .probeDirty(probeDirty)
  );

  xlat_control #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_ctl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqSize(reqSize), .flush(flush), .wrEn(wrEn),
    .matchVec(matchVec), .selPfn(selPfn), .selRo(selRo),
    .selIdx(selIdx), .ctl(ctl),
    .rspValid(rspValid), .rspPhysAddr(rspPhysAddr), .rspExc(rspExc)
  );

endmodule

// File: rtl/xlat_checks.sv
module xlat_checks #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        reqSize,
  input logic              flush,
  input logic              probeValid,
  input logic              rspValid,
  input logic [ADDR_W-1:0] rspPhysAddr,
  input logic [1:0]        rspExc
);

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && rspValid == rspValid) |=>
      (rspExc != 2'd0 || rspPhysAddr[OFFS_W-1:0] == $past(reqAddr[OFFS_W-1:0])));

  p_fault_no_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspExc != 2'd0) |-> rspPhysAddr == '0);

  p_misalign_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize[1] && reqAddr[1:0] != 2'b00) |=> rspExc == 2'd3);

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !probeValid);

endmodule

bind page_xlate_buffer xlat_checks #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
  .reqSize(reqSize), .flush(flush), .probeValid(probeValid),
  .rspValid(rspValid), .rspPhysAddr(rspPhysAddr), .rspExc(rspExc)
);

// File: tb/page_xlate_buffer_test.sv
`timescale 1ns/1ps
module page_xlate_buffer_test;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        flush = 1'b0, wrEn = 1'b0, wrValid = 1'b0, wrReadOnly = 1'b0;
  logic [1:0]  wrIdx = '0, probeIdx = '0;
  logic [24:0] wrVpn = '0, wrPfn = '0;
  logic        probeValid, probeUse, probeDirty, rspValid;
  logic [31:0] rspPhysAddr;
  logic [1:0]  rspExc;

  int total = 0;
  int fails = 0;

  // Bench model of the buffer contents
  logic [24:0] mVpn [N];
  logic [24:0] mPfn [N];
  logic        mValid [N], mRo [N], mUse [N], mDirty [N];

  always #2 clk = ~clk;

  page_xlate_buffer uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqSize(reqSize), .flush(flush), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrVpn(wrVpn), .wrPfn(wrPfn), .wrValid(wrValid),
    .wrReadOnly(wrReadOnly), .probeIdx(probeIdx), .probeValid(probeValid),
    .probeUse(probeUse), .probeDirty(probeDirty), .rspValid(rspValid),
    .rspPhysAddr(rspPhysAddr), .rspExc(rspExc)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] a, input logic w,
                                input logic [1:0] sz, output logic [1:0] exc,
                                output logic [31:0] pa, output int idx);
    idx = -1;
    pa  = '0;
    for (int i = N - 1; i >= 0; i--)
      if (mValid[i] && mVpn[i] == a[31:7]) idx = i;
    if ((sz == 2'd1 && a[0]) || (sz[1] && a[1:0] != 2'b00)) exc = 2'd3;
    else if (idx < 0)                                      exc = 2'd1;
    else if (w && mRo[idx])                                exc = 2'd2;
    else begin
      exc = 2'd0;
      pa  = {mPfn[idx], a[6:0]};
    end
  endfunction

  task automatic lookup(string tag, logic [31:0] a, logic w, logic [1:0] sz);
    logic [1:0]  eExc;
    logic [31:0] ePa;
    int          idx;
    model(a, w, sz, eExc, ePa, idx);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWrite = w; reqSize = sz;
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " rspValid"}, 32'(rspValid), 32'd1);
    check({tag, " exc"}, 32'(rspExc), 32'(eExc));
    check({tag, " addr"}, rspPhysAddr, ePa);
    if (eExc == 2'd0) begin
      mUse[idx] = 1'b1;
      if (w) mDirty[idx] = 1'b1;
    end
  endtask

  task automatic loadEntry(int i, logic [24:0] v, logic [24:0] p, logic val,
                           logic ro, logic withFlush);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 2'(i); wrVpn = v; wrPfn = p;
    wrValid = val; wrReadOnly = ro; flush = withFlush;
    @(negedge clk);
    wrEn = 1'b0; flush = 1'b0;
    if (withFlush) for (int k = 0; k < N; k++) mValid[k] = 1'b0;
    mVpn[i] = v; mPfn[i] = p; mRo[i] = ro; mUse[i] = 1'b0; mDirty[i] = 1'b0;
    mValid[i] = val && !withFlush;
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int k = 0; k < N; k++) mValid[k] = 1'b0;
  endtask

  task automatic probeAll(string tag);
    for (int i = 0; i < N; i++) begin
      probeIdx = 2'(i);
      #0.5;
      check({tag, " valid"}, 32'(probeValid), 32'(mValid[i]));
      check({tag, " use"},   32'(probeUse),   32'(mUse[i]));
      check({tag, " dirty"}, 32'(probeDirty), 32'(mDirty[i]));
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int i = 0; i < N; i++) begin
      mVpn[i] = '0; mPfn[i] = '0; mValid[i] = 0; mRo[i] = 0; mUse[i] = 0; mDirty[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rspValid after reset", 32'(rspValid), 32'd0);
    probeAll("R1 reset");
    lookup("R3 empty buffer", 32'h0000_0280, 1'b0, 2'd2);

    loadEntry(0, 25'd5, 25'h123, 1, 0, 0);
    loadEntry(1, 25'd9, 25'h077, 1, 1, 0);
    loadEntry(2, 25'd5, 25'h999, 1, 0, 0);
    loadEntry(3, 25'd12, 25'h0AA, 0, 0, 0);
    probeAll("R11 loaded");
    lookup("R2 R10 duplicate hit", {25'd5, 7'h2C}, 1'b0, 2'd2);
    probeAll("R6 after read");
    lookup("R4 write protected", {25'd9, 7'h10}, 1'b1, 2'd2);
    probeAll("R4 no flag change");
    lookup("R12 read protected", {25'd9, 7'h13}, 1'b0, 2'd0);
    lookup("R7 write hit", {25'd5, 7'h42}, 1'b1, 2'd1);
    probeAll("R7 flags");
    lookup("R11 invalid entry", {25'd12, 7'h00}, 1'b0, 2'd0);
    lookup("R5 word misaligned miss", {25'd40, 7'h02}, 1'b0, 2'd2);
    lookup("R5 half odd hit page", {25'd5, 7'h01}, 1'b1, 2'd1);
    lookup("R5 word size3 misaligned", {25'd5, 7'h03}, 1'b0, 2'd3);
    lookup("R5 byte odd ok", {25'd5, 7'h01}, 1'b0, 2'd0);
    probeAll("R5 no flag change");
    loadEntry(0, 25'd5, 25'h124, 1, 0, 0);
    probeAll("R11 reload clears flags");
    loadEntry(3, 25'd7, 25'h055, 1, 0, 1);
    probeAll("R9 R8 flush with write");
    lookup("R8 after flush", {25'd5, 7'h00}, 1'b0, 2'd2);
    lookup("R9 written entry invalid", {25'd7, 7'h00}, 1'b0, 2'd2);

    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom_range(0, 9));
      if (op < 2) begin
        loadEntry(int'($urandom_range(0, 3)), 25'($urandom_range(1, 6)),
                  25'($urandom), 1'($urandom_range(0, 4) != 0),
                  1'($urandom_range(0, 3) == 0), 0);
      end else if (op == 2 && $urandom_range(0, 4) == 0) begin
        doFlush();
        probeAll("R8 random flush");
      end else begin
        lookup("R2 random", {25'($urandom_range(1, 7)), 7'($urandom)},
               1'($urandom), 2'($urandom));
      end
      if (n % 50 == 0) probeAll("R6 R7 random flags");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule